// File: doc/BRIEF.md
# Two-Level Cascaded Priority Interrupt Controller

This block merges up to fifteen interrupt sources into one request toward a processor core. It has two eight-input priority controllers. The secondary controller's request output is wired into input 2 of the primary controller. A secondary request therefore competes in the primary's arbitration like any local line. Priority is fixed in each controller, with line 0 the most urgent and line 7 the least. Each controller has its own mask, trigger mode, vector base and end-of-service command.

The core answers a raised request with two acknowledge pulses. On the first pulse, the winning request moves from pending to in-service. From then until the vector has been delivered, a 3-bit cascade code names the controller that owns the request. On the second pulse, the owning controller's vector is registered and presented for one cycle. A request that has vanished by the first pulse yields the owner's line-7 vector.

Three configuration inputs change the wiring. One picks serial-port or pin sources for primary lines 6 and 7. One exchanges two secondary inputs. One places the cascade code on three upper address outputs.

Top module: `irq_cascade_top`

## Requirements
- R1: After reset both controllers hold no pending and no in-service lines, `int_core` and `vec_valid` are 0, and `cas_code` is 3'b111.
- R2: Within a controller, the unmasked pending line with the lowest index wins. A line whose mask bit is 1 never wins.
- R3: `int_core` is 1 exactly when the primary's winning line has a lower index than every primary line in service.
- R4: The secondary controller's request drives primary line 2. It is raised only for an unmasked secondary line whose index is below every secondary line in service.
- R5: The first `inta` pulse while idle sets the in-service bit of the winner and clears its pending bit. `cas_code` then reads 3'd2 if the secondary owns the request, or 3'd0 if the primary owns it. That value holds from the next cycle through the vector cycle. Outside an acknowledge sequence `cas_code` is 3'b111.
- R6: In the cycle after the second `inta` pulse, `vec_valid` is 1 for one cycle and `vec` equals {owner base (5 bits), winning line (3 bits)}.
- R7: If the owning controller has no raised request at the first pulse, its code is 7 and no in-service bit is set.
- R8: A one-cycle end-of-service pulse clears the lowest-index in-service bit of its controller.
- R9: In edge mode a line becomes pending on a 0-to-1 input change and stays pending after the input falls. In level mode the pending bit follows the input with one cycle of delay.
- R10: With `cfg_route_sio`=0, primary lines 6 and 7 take `pin_hi[0]` and `pin_hi[1]`. With `cfg_route_sio`=1 they take `sio_irq[0]` and `sio_irq[1]`, and `pin_hi` has no effect.
- R11: With `cfg_swap_dma`=0, secondary line 4 is `ext_swap_pin` and line 5 is `dma_irq`. With `cfg_swap_dma`=1 the two are exchanged.
- R12: `addr_hi_out` equals `cas_code` when `cfg_cas_on_addr`=1, and equals `addr_hi_in` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_pin | input | 5 | Primary lines 0,1,3,4,5 (bits 0..4) |
| pin_hi | input | 2 | Pin sources for primary lines 6,7 |
| sio_irq | input | 2 | Serial-port sources for primary lines 6,7 |
| slv_pin | input | 6 | Secondary lines 0..3 (bits 0..3) and 6,7 (bits 4,5) |
| ext_swap_pin | input | 1 | Exchangeable pin source for secondary line 4 or 5 |
| dma_irq | input | 1 | DMA source for secondary line 5 or 4 |
| cfg_route_sio | input | 1 | Selects serial sources for primary lines 6,7 |
| cfg_swap_dma | input | 1 | Exchanges secondary lines 4 and 5 |
| cfg_cas_on_addr | input | 1 | Puts the cascade code on `addr_hi_out` |
| mst_mask | input | 8 | Primary mask, 1 blocks the line |
| slv_mask | input | 8 | Secondary mask, 1 blocks the line |
| mst_base | input | 5 | Primary vector base |
| slv_base | input | 5 | Secondary vector base |
| mst_edge | input | 1 | Primary trigger mode, 1 = edge |
| slv_edge | input | 1 | Secondary trigger mode, 1 = edge |
| mst_eoi | input | 1 | Primary end-of-service pulse |
| slv_eoi | input | 1 | Secondary end-of-service pulse |
| inta | input | 1 | Acknowledge pulse from the core |
| int_core | output | 1 | Interrupt request to the core |
| vec | output | 8 | Vector byte |
| vec_valid | output | 1 | Vector present |
| cas_code | output | 3 | Owner code during acknowledge |
| addr_hi_in | input | 3 | Normal upper address bits |
| addr_hi_out | output | 3 | Upper address bits after cascade override |

## Verification
A wrong pending or in-service bit shows on `int_core` within one cycle for a primary line, and within two cycles for a secondary line, because the secondary request is registered again as primary line 2. A wrong owner or a wrong latched line number shows in `cas_code` in the cycle after the first pulse. It also shows in `vec` in the cycle after the second pulse. A stale in-service bit shows later: a request that should be raised after an end-of-service command stays silent.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
    localparam int IRQ_LINES    = 8;
    localparam int IDX_W        = $clog2(IRQ_LINES);
    localparam int VEC_W        = 8;
    localparam int BASE_W       = VEC_W - IDX_W;
    localparam int CASCADE_PORT = 2;
    localparam int MST_PIN_W    = 5;
    localparam int SLV_PIN_W    = 6;
    localparam int HI_SRC_W     = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GAP  = 2'd1,
        PH_VEC  = 2'd2
    } ack_phase_e;
endpackage

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
    import irq_cascade_pkg::*;
#(
    parameter int N  = IRQ_LINES,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  mask,
    input  logic          edge_mode,
    input  logic          eoi,
    input  logic          ack,
    output logic          int_out,
    output logic [IW-1:0] next_code,
    output logic [N-1:0]  isr_o
);
    localparam logic [IW:0]   NONE = (IW+1)'(N);
    localparam logic [IW-1:0] SPUR = IW'(N-1);

    typedef struct packed {
        logic [N-1:0] irr;
        logic [N-1:0] isr;
        logic [N-1:0] prev;
    } unit_st_t;

    unit_st_t s_d, s_q;
    logic [IW:0] win_p;
    logic [IW:0] svc_p;

    function automatic logic [IW:0] first_set(input logic [N-1:0] v);
        logic [IW:0] r;
        r = NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) r = (IW+1)'(i);
        end
        return r;
    endfunction

    always_comb begin
        win_p     = first_set(s_q.irr & ~mask);
        svc_p     = first_set(s_q.isr);
        int_out   = (win_p < svc_p);
        next_code = int_out ? win_p[IW-1:0] : SPUR;

        s_d      = s_q;
        s_d.prev = req;
        s_d.irr  = edge_mode ? (s_q.irr | (req & ~s_q.prev)) : req;
        if (eoi && (svc_p != NONE)) begin
            s_d.isr[svc_p[IW-1:0]] = 1'b0;
        end
        if (ack && int_out) begin
            s_d.isr[win_p[IW-1:0]] = 1'b1;
            s_d.irr[win_p[IW-1:0]] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign isr_o = s_q.isr;
endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_cascade_pkg::*;
(
    input  logic [MST_PIN_W-1:0] mst_pin,
    input  logic [HI_SRC_W-1:0]  pin_hi,
    input  logic [HI_SRC_W-1:0]  sio_irq,
    input  logic [SLV_PIN_W-1:0] slv_pin,
    input  logic                 ext_swap_pin,
    input  logic                 dma_irq,
    input  logic                 cfg_route_sio,
    input  logic                 cfg_swap_dma,
    input  logic                 slave_int,
    output logic [IRQ_LINES-1:0] mst_req,
    output logic [IRQ_LINES-1:0] slv_req
);
    logic [HI_SRC_W-1:0] hi_src;

    always_comb begin
        hi_src  = cfg_route_sio ? sio_irq : pin_hi;
        mst_req = {hi_src, mst_pin[4:2], slave_int, mst_pin[1:0]};
        slv_req = {slv_pin[5:4],
                   cfg_swap_dma ? ext_swap_pin : dma_irq,
                   cfg_swap_dma ? dma_irq : ext_swap_pin,
                   slv_pin[3:0]};
    end
endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
    import irq_cascade_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MST_PIN_W-1:0] mst_pin,
    input  logic [HI_SRC_W-1:0]  pin_hi,
    input  logic [HI_SRC_W-1:0]  sio_irq,
    input  logic [SLV_PIN_W-1:0] slv_pin,
    input  logic                 ext_swap_pin,
    input  logic                 dma_irq,
    input  logic                 cfg_route_sio,
    input  logic                 cfg_swap_dma,
    input  logic                 cfg_cas_on_addr,
    input  logic [IRQ_LINES-1:0] mst_mask,
    input  logic [IRQ_LINES-1:0] slv_mask,
    input  logic [BASE_W-1:0]    mst_base,
    input  logic [BASE_W-1:0]    slv_base,
    input  logic                 mst_edge,
    input  logic                 slv_edge,
    input  logic                 mst_eoi,
    input  logic                 slv_eoi,
    input  logic                 inta,
    output logic                 int_core,
    output logic [VEC_W-1:0]     vec,
    output logic                 vec_valid,
    output logic [IDX_W-1:0]     cas_code,
    input  logic [IDX_W-1:0]     addr_hi_in,
    output logic [IDX_W-1:0]     addr_hi_out
);
    localparam logic [IDX_W-1:0] SLAVE_CODE = IDX_W'(CASCADE_PORT);
    localparam logic [IDX_W-1:0] CAS_IDLE   = '1;

    typedef struct packed {
        ack_phase_e       phase;
        logic             to_slave;
        logic [IDX_W-1:0] code;
        logic [VEC_W-1:0] vec;
    } seq_st_t;

    seq_st_t s_d, s_q;

    logic [IRQ_LINES-1:0] mst_req, slv_req;
    logic                 slv_int, mst_int;
    logic [IDX_W-1:0]     mst_code, slv_code;
    logic [IRQ_LINES-1:0] mst_isr, slv_isr;
    logic                 mst_ack, slv_ack;

    irq_route u_route (
        .mst_pin       (mst_pin),
        .pin_hi        (pin_hi),
        .sio_irq       (sio_irq),
        .slv_pin       (slv_pin),
        .ext_swap_pin  (ext_swap_pin),
        .dma_irq       (dma_irq),
        .cfg_route_sio (cfg_route_sio),
        .cfg_swap_dma  (cfg_swap_dma),
        .slave_int     (slv_int),
        .mst_req       (mst_req),
        .slv_req       (slv_req)
    );

    irq_prio_unit #(.N(IRQ_LINES)) u_slv (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (slv_req),
        .mask      (slv_mask),
        .edge_mode (slv_edge),
        .eoi       (slv_eoi),
        .ack       (slv_ack),
        .int_out   (slv_int),
        .next_code (slv_code),
        .isr_o     (slv_isr)
    );

    irq_prio_unit #(.N(IRQ_LINES)) u_mst (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (mst_req),
        .mask      (mst_mask),
        .edge_mode (mst_edge),
        .eoi       (mst_eoi),
        .ack       (mst_ack),
        .int_out   (mst_int),
        .next_code (mst_code),
        .isr_o     (mst_isr)
    );

    always_comb begin
        mst_ack = inta && (s_q.phase == PH_IDLE);
        slv_ack = mst_ack && (mst_code == SLAVE_CODE);

        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (inta) begin
                    s_d.phase    = PH_GAP;
                    s_d.to_slave = (mst_code == SLAVE_CODE);
                    s_d.code     = (mst_code == SLAVE_CODE) ? slv_code : mst_code;
                end
            end
            PH_GAP: begin
                if (inta) begin
                    s_d.phase = PH_VEC;
                    s_d.vec   = {s_q.to_slave ? slv_base : mst_base, s_q.code};
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, to_slave: 1'b0, code: '0, vec: '0};
        else        s_q <= s_d;
    end

    always_comb begin
        int_core    = mst_int;
        vec         = s_q.vec;
        vec_valid   = (s_q.phase == PH_VEC);
        cas_code    = (s_q.phase == PH_IDLE) ? CAS_IDLE
                    : (s_q.to_slave ? SLAVE_CODE : '0);
        addr_hi_out = cfg_cas_on_addr ? cas_code : addr_hi_in;
    end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
    import irq_cascade_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [VEC_W-1:0]     vec,
    input logic                 vec_valid,
    input logic [IDX_W-1:0]     cas_code,
    input logic [BASE_W-1:0]    mst_base,
    input logic [BASE_W-1:0]    slv_base,
    input logic [IRQ_LINES-1:0] mst_isr,
    input logic [IRQ_LINES-1:0] slv_isr
);
    assert_vec_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    assert_vec_slave_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && cas_code == IDX_W'(CASCADE_PORT)) |->
            vec[VEC_W-1:IDX_W] == $past(slv_base));

    assert_vec_master_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && cas_code == '0) |-> vec[VEC_W-1:IDX_W] == $past(mst_base));

    assert_cas_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (cas_code == '0 || cas_code == IDX_W'(CASCADE_PORT)));

    assert_mst_isr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mst_isr) <= $countones($past(mst_isr)) + 1);

    assert_slv_isr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slv_isr) <= $countones($past(slv_isr)) + 1);
endmodule

bind irq_cascade_top irq_cascade_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec       (vec),
    .vec_valid (vec_valid),
    .cas_code  (cas_code),
    .mst_base  (mst_base),
    .slv_base  (slv_base),
    .mst_isr   (mst_isr),
    .slv_isr   (slv_isr)
);

// File: tb/sim_irq_cascade_top.sv
module sim_irq_cascade_top;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;
    localparam logic [4:0] MB = 5'h08;
    localparam logic [4:0] SB = 5'h0E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] mst_pin = '0;
    logic [1:0] pin_hi = '0, sio_irq = '0;
    logic [5:0] slv_pin = '0;
    logic ext_swap_pin = 1'b0, dma_irq = 1'b0;
    logic cfg_route_sio = 1'b0, cfg_swap_dma = 1'b0, cfg_cas_on_addr = 1'b0;
    logic [7:0] mst_mask = '0, slv_mask = '0;
    logic [4:0] mst_base = MB, slv_base = SB;
    logic mst_edge = 1'b0, slv_edge = 1'b0, mst_eoi = 1'b0, slv_eoi = 1'b0, inta = 1'b0;
    logic int_core, vec_valid;
    logic [7:0] vec;
    logic [2:0] cas_code, addr_hi_out;
    logic [2:0] addr_hi_in = 3'b101;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cascade_top u0 (.*);

    // reference model state: index 0 primary, 1 secondary
    logic [7:0] m_irr [2];
    logic [7:0] m_isr [2];
    logic [7:0] m_prev [2];
    int         m_phase;
    bit         m_owner;
    logic [2:0] m_code;
    logic [7:0] m_vec;

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic int pick(input int k, input logic [7:0] msk);
        int w, t;
        w = lowest(m_irr[k] & ~msk);
        t = lowest(m_isr[k]);
        return (w < t) ? w : 8;
    endfunction

    task automatic step_unit(input int k, input logic [7:0] rq, input bit edg,
                             input bit eoi, input bit ack, input int p);
        logic [7:0] nirr, nisr;
        int t;
        nirr = edg ? (m_irr[k] | (rq & ~m_prev[k])) : rq;
        nisr = m_isr[k];
        t = lowest(m_isr[k]);
        if (eoi && t < 8) nisr[t] = 1'b0;
        if (ack && p < 8) begin nisr[p] = 1'b1; nirr[p] = 1'b0; end
        m_irr[k] = nirr; m_isr[k] = nisr; m_prev[k] = rq;
    endtask

    always @(posedge clk or negedge rst_n) begin : model
        int sp, mp;
        bit p1, sack;
        logic [7:0] sr, mr;
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin m_irr[k] = '0; m_isr[k] = '0; m_prev[k] = '0; end
            m_phase = 0; m_owner = 0; m_code = '0; m_vec = '0;
        end else begin
            sp = pick(1, slv_mask);
            mp = pick(0, mst_mask);
            sr = {slv_pin[5:4], cfg_swap_dma ? ext_swap_pin : dma_irq,
                  cfg_swap_dma ? dma_irq : ext_swap_pin, slv_pin[3:0]};
            mr = {cfg_route_sio ? sio_irq : pin_hi, mst_pin[4:2], (sp != 8), mst_pin[1:0]};
            p1 = inta && (m_phase == 0);
            sack = p1 && (mp == 2);
            step_unit(0, mr, mst_edge, mst_eoi, p1, mp);
            step_unit(1, sr, slv_edge, slv_eoi, sack, sp);
            case (m_phase)
                0: if (inta) begin
                    m_phase = 1; m_owner = sack;
                    m_code = sack ? ((sp == 8) ? 3'd7 : 3'(sp)) : ((mp == 8) ? 3'd7 : 3'(mp));
                end
                1: if (inta) begin
                    m_phase = 2;
                    m_vec = {m_owner ? slv_base : mst_base, m_code};
                end
                default: m_phase = 0;
            endcase
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always begin
        logic [2:0] ecas;
        @(negedge clk);
        #2;
        if (rst_n) begin
            ecas = (m_phase == 0) ? 3'b111 : (m_owner ? 3'd2 : 3'd0);
            check("R3 int_core model", {7'd0, int_core}, {7'd0, pick(0, mst_mask) != 8});
            check("R5 cas_code model", {5'd0, cas_code}, {5'd0, ecas});
            check("R6 vec_valid model", {7'd0, vec_valid}, {7'd0, m_phase == 2});
            if (m_phase == 2) check("R6 vec model", vec, m_vec);
            check("R12 addr_hi_out model", {5'd0, addr_hi_out},
                  {5'd0, cfg_cas_on_addr ? ecas : addr_hi_in});
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic ack_seq(output logic [7:0] v, output logic vld,
                           output logic [2:0] c1, output logic [2:0] a1);
        inta = 1'b1;
        @(negedge clk); inta = 1'b0; #1;
        c1 = cas_code; a1 = addr_hi_out;
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0; #1;
        v = vec; vld = vec_valid;
    endtask

    task automatic clear_all();
        mst_pin = '0; pin_hi = '0; sio_irq = '0; slv_pin = '0;
        ext_swap_pin = 0; dma_irq = 0; cfg_route_sio = 0; cfg_swap_dma = 0;
        cfg_cas_on_addr = 0; mst_mask = '0; slv_mask = '0; mst_base = MB; slv_base = SB;
        mst_edge = 0; slv_edge = 0; inta = 0;
        wait_cyc(3);
        mst_eoi = 1; slv_eoi = 1;
        wait_cyc(8);
        mst_eoi = 0; slv_eoi = 0;
        wait_cyc(2);
    endtask

    task automatic pulse_eoi_mst();
        mst_eoi = 1; wait_cyc(1); mst_eoi = 0;
    endtask

    initial begin : main
        logic [7:0] v;
        logic vld;
        logic [2:0] c1, a1;
        int seed_d;
        seed_d = $urandom(32'd2024);

        // R1 reset state
        wait_cyc(3);
        check("R1 int_core in reset", {7'd0, int_core}, 8'd0);
        check("R1 cas idle in reset", {5'd0, cas_code}, 8'd7);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 vec_valid after reset", {7'd0, vec_valid}, 8'd0);
        check("R1 int_core after reset", {7'd0, int_core}, 8'd0);

        // R2 R3 R8 priority, in-service blocking, end of service
        clear_all();
        mst_pin = 5'b00011;
        wait_cyc(1);
        check("R3 raised", {7'd0, int_core}, 8'd1);
        ack_seq(v, vld, c1, a1);
        check("R2 line 0 wins", v, {MB, 3'd0});
        check("R6 vec_valid", {7'd0, vld}, 8'd1);
        check("R5 primary owner code", {5'd0, c1}, 8'd0);
        wait_cyc(1);
        check("R6 vec_valid one cycle", {7'd0, vec_valid}, 8'd0);
        check("R3 blocked by in-service", {7'd0, int_core}, 8'd0);
        mst_pin = 5'b00010;
        pulse_eoi_mst();
        check("R8 raised after eoi", {7'd0, int_core}, 8'd1);
        ack_seq(v, vld, c1, a1);
        check("R8 next line served", v, {MB, 3'd1});
        mst_mask = 8'h01; mst_pin = 5'b00001;
        wait_cyc(3);
        check("R2 masked line silent", {7'd0, int_core}, 8'd0);

        // R4 R5 R12 secondary path
        clear_all();
        cfg_cas_on_addr = 1;
        slv_pin = 6'b001000;
        wait_cyc(2);
        check("R4 secondary raises core", {7'd0, int_core}, 8'd1);
        ack_seq(v, vld, c1, a1);
        check("R5 secondary owner code", {5'd0, c1}, 8'd2);
        check("R12 cascade on address", {5'd0, a1}, 8'd2);
        check("R4 secondary vector", v, {SB, 3'd3});
        wait_cyc(1);
        check("R12 idle code on address", {5'd0, addr_hi_out}, 8'd7);
        cfg_cas_on_addr = 0; #1;
        check("R12 address passthrough", {5'd0, addr_hi_out}, {5'd0, addr_hi_in});
        slv_pin = '0;
        pulse_eoi_mst();
        dma_irq = 1;
        wait_cyc(3);
        check("R4 lower secondary blocked", {7'd0, int_core}, 8'd0);
        slv_pin = 6'b000010;
        wait_cyc(2);
        check("R4 higher secondary passes", {7'd0, int_core}, 8'd1);
        ack_seq(v, vld, c1, a1);
        check("R4 nested secondary vector", v, {SB, 3'd1});
        clear_all();
        slv_mask = 8'h08; slv_pin = 6'b001000;
        wait_cyc(3);
        check("R4 secondary mask", {7'd0, int_core}, 8'd0);

        // R7 spurious
        clear_all();
        mst_pin = 5'b00001;
        wait_cyc(1);
        check("R7 raised first", {7'd0, int_core}, 8'd1);
        mst_pin = '0;
        wait_cyc(2);
        ack_seq(v, vld, c1, a1);
        check("R7 spurious vector", v, {MB, 3'd7});
        pin_hi = 2'b10;
        wait_cyc(2);
        check("R7 no in-service set", {7'd0, int_core}, 8'd1);

        // R9 edge versus level
        clear_all();
        mst_edge = 1; mst_pin = 5'b00100;
        wait_cyc(1);
        mst_pin = '0;
        wait_cyc(2);
        check("R9 edge latched", {7'd0, int_core}, 8'd1);
        ack_seq(v, vld, c1, a1);
        check("R9 edge vector", v, {MB, 3'd3});
        clear_all();
        mst_pin = 5'b00100;
        wait_cyc(1);
        mst_pin = '0;
        wait_cyc(2);
        check("R9 level follows input", {7'd0, int_core}, 8'd0);

        // R10 routing
        clear_all();
        cfg_route_sio = 1; pin_hi = 2'b11;
        wait_cyc(2);
        check("R10 pins ignored", {7'd0, int_core}, 8'd0);
        sio_irq = 2'b01;
        wait_cyc(1);
        ack_seq(v, vld, c1, a1);
        check("R10 serial source line 6", v, {MB, 3'd6});

        // R11 swap
        clear_all();
        cfg_swap_dma = 1; dma_irq = 1;
        wait_cyc(2);
        ack_seq(v, vld, c1, a1);
        check("R11 dma on line 4", v, {SB, 3'd4});
        clear_all();
        cfg_swap_dma = 1; ext_swap_pin = 1;
        wait_cyc(2);
        ack_seq(v, vld, c1, a1);
        check("R11 pin on line 5", v, {SB, 3'd5});
        clear_all();

        // random traffic, checked by the model every cycle
        for (int n = 0; n < RAND_CYCLES; n++) begin
            @(negedge clk);
            mst_pin = 5'($urandom & $urandom);
            pin_hi = 2'($urandom & $urandom);
            sio_irq = 2'($urandom & $urandom);
            slv_pin = 6'($urandom & $urandom);
            ext_swap_pin = ($urandom_range(0, 3) == 0);
            dma_irq = ($urandom_range(0, 3) == 0);
            inta = ($urandom_range(0, 5) == 0);
            mst_eoi = ($urandom_range(0, 15) == 0);
            slv_eoi = ($urandom_range(0, 15) == 0);
            addr_hi_in = 3'($urandom);
            if ($urandom_range(0, 63) == 0) begin
                cfg_route_sio = 1'($urandom); cfg_swap_dma = 1'($urandom);
                cfg_cas_on_addr = 1'($urandom);
                mst_mask = 8'($urandom & $urandom); slv_mask = 8'($urandom & $urandom);
                mst_base = 5'($urandom); slv_base = 5'($urandom);
                mst_edge = 1'($urandom); slv_edge = 1'($urandom);
            end
        end
        @(negedge clk);
        inta = 0; mst_eoi = 0; slv_eoi = 0;
        wait_cyc(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule